// File: doc/BRIEF.md
# Calendar Time Counter with Selectable BCD or Binary Encoding

This block holds wall-clock time and a calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick from elsewhere in the chip starts an update. The block raises an update-in-progress flag for a fixed number of clock cycles before any field moves, so a host that samples the flag low knows the fields will stay stable for that long. When the update lands, an update-ended pulse follows.

A run-time data-mode input picks BCD or plain binary for every field. A second input picks 24-hour or 12-hour hours. The arithmetic increments, compares and wraps directly in the encoding that is selected, so the block never converts between encodings. To set the time, the host raises a halt input. While halt is high, counting stops and the host can write any single field through a small load port. When halt drops, counting resumes from the values that were written.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset: seconds, minutes, hours and year read 0x00; day of week, day and month read 0x01; `uip_o` and `upd_done_o` are low.
- R2: A `tick_i` pulse while `set_i` is low raises `uip_o` on the next cycle. `uip_o` stays high for exactly `UIP_LEAD` cycles. The fields change on the clock edge that lowers `uip_o`.
- R3: `upd_done_o` is high for exactly one cycle: the cycle right after the edge on which the fields changed.
- R4: The seconds field steps through 00..59. Going from 59 to 00 steps the minutes field, which also runs 00..59 and carries into the hours field in the same way.
- R5: In 24-hour mode (`hr24_i`=1), hours run 00..23. Going from 23 to 00 starts a day rollover.
- R6: In 12-hour mode (`hr24_i`=0), bit 7 of the hour field is PM and bits 6:0 hold the hour, in the order 12, 1, ..., 11. Going from 11 to 12 flips PM. From 11 PM the hour goes to 12 AM and starts a day rollover; from 11 AM it goes to 12 PM without one.
- R7: On a day rollover, the day of month goes back to 01 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is divisible by 4 (year 00 included) and 28 days otherwise. All other months have 31 days.
- R8: Going from day 31 to 01 in month 12 takes the month back to 01 and steps the year. The year goes from 99 to 00.
- R9: Each day rollover steps the day of week by one, and 07 goes to 01.
- R10: While `set_i`=1, ticks are ignored, no field counts, and `uip_o` and `upd_done_o` stay low. A load (`ld_en_i`) writes `ld_data_i` into the field chosen by `ld_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day, 5 month, 6 year. With `set_i`=0, loads are ignored.
- R11: Changing `bin_mode_i` or `hr24_i` does not alter any stored field. Later steps use the arithmetic of the new mode on the stored bits.
- R12: With `bin_mode_i`=0 (BCD), a low digit of 9 carries into the upper digit (0x09 to 0x10, 0x19 to 0x20). With `bin_mode_i`=1 (binary), fields step by plain addition (0x09 to 0x0A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| set_i | input | 1 | Halt counting and allow loads |
| bin_mode_i | input | 1 | Field encoding: 0 BCD, 1 binary |
| hr24_i | input | 1 | Hour format: 1 for 24-hour, 0 for 12-hour with PM in bit 7 |
| ld_en_i | input | 1 | Load strobe |
| ld_sel_i | input | 3 | Field chosen for the load |
| ld_data_i | input | 8 | Value to load |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| day_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | Update-ended pulse |

## Verification
A wrong carry or wrong wrap limit shows up in the field outputs on the first update that crosses that boundary. The bench therefore loads each boundary value directly and applies a single tick, so the error is visible `UIP_LEAD` cycles later. A fault in the update sequencer shows up as `uip_o` staying high for too long or too short a time, or as an update-ended pulse that is missing, doubled or arrives without a matching expected snapshot. A mode or halt fault shows up as stored bits changing during a cycle in which nothing should have stepped them.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef logic [7:0] fld_t;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DOW  = 3'd3,
    SEL_DAY  = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6
  } fld_sel_e;

  typedef struct packed {
    fld_t val;
    logic wrap;
  } stp_t;

  // Express a small integer in the selected encoding.
  function automatic fld_t enc(input logic [6:0] n, input logic bin);
    logic [3:0] tens, units;
    tens  = 4'(n / 7'd10);
    units = 4'(n % 7'd10);
    return bin ? {1'b0, n} : {tens, units};
  endfunction

  // Recover the integer value of a field.
  function automatic logic [6:0] dec(input fld_t v, input logic bin);
    return bin ? v[6:0] : 7'(7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  // Add one in the selected encoding.
  function automatic fld_t inc(input fld_t v, input logic bin);
    if (bin || v[3:0] != 4'd9) return v + 8'd1;
    return {v[7:4] + 4'd1, 4'd0};
  endfunction

  // Step with a wrap from hi back to lo.
  function automatic stp_t step_wrap(input fld_t v, input logic bin,
                                     input logic [6:0] lo, input logic [6:0] hi);
    stp_t r;
    r.wrap = (v == enc(hi, bin));
    r.val  = r.wrap ? enc(lo, bin) : inc(v, bin);
    return r;
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2:                     return ((y % 7'd4) == 7'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  // Hour step for both formats; wrap marks a day rollover.
  function automatic stp_t hour_next(input fld_t h, input logic bin, input logic hr24);
    stp_t r;
    fld_t hv, nx;
    if (hr24) return step_wrap(h, bin, 7'd0, 7'd23);
    hv     = {1'b0, h[6:0]};
    r.wrap = 1'b0;
    if (hv == enc(7'd12, bin)) begin
      nx    = enc(7'd1, bin);
      r.val = {h[7], nx[6:0]};
    end else if (hv == enc(7'd11, bin)) begin
      nx     = enc(7'd12, bin);
      r.val  = {~h[7], nx[6:0]};
      r.wrap = h[7];
    end else begin
      nx    = inc(hv, bin);
      r.val = {h[7], nx[6:0]};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_uip_seq.sv
module rtc_uip_seq #(
  parameter int LEAD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic halt_i,
  output logic uip_o,
  output logic step_o
);
  localparam int CW = $clog2(LEAD + 1);

  logic [CW-1:0] cnt_q;

  assign uip_o  = (cnt_q != '0);
  assign step_o = (cnt_q == CW'(1)) && !halt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (halt_i)                  cnt_q <= '0;
    else if (cnt_q != '0)             cnt_q <= cnt_q - CW'(1);
    else if (tick_i)                  cnt_q <= CW'(LEAD);
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       bin_i,
  input  logic       hr24_i,
  input  logic       ld_i,
  input  fld_sel_e   ld_sel_i,
  input  fld_t       ld_data_i,
  output fld_t       sec_o,
  output fld_t       min_o,
  output fld_t       hour_o,
  output logic       day_roll_o
);
  fld_t sec_q, min_q, hour_q;
  stp_t s_nx, m_nx, h_nx;

  always_comb begin
    s_nx = step_wrap(sec_q, bin_i, 7'd0, 7'd59);
    m_nx = step_wrap(min_q, bin_i, 7'd0, 7'd59);
    h_nx = hour_next(hour_q, bin_i, hr24_i);
  end

  assign day_roll_o = step_i && s_nx.wrap && m_nx.wrap && h_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (ld_i) begin
      case (ld_sel_i)
        SEL_SEC:  sec_q  <= ld_data_i;
        SEL_MIN:  min_q  <= ld_data_i;
        SEL_HOUR: hour_q <= ld_data_i;
        default:  ;
      endcase
    end else if (step_i) begin
      sec_q <= s_nx.val;
      if (s_nx.wrap) min_q <= m_nx.val;
      if (s_nx.wrap && m_nx.wrap) hour_q <= h_nx.val;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_step_i,
  input  logic       bin_i,
  input  logic       ld_i,
  input  fld_sel_e   ld_sel_i,
  input  fld_t       ld_data_i,
  output fld_t       dow_o,
  output fld_t       day_o,
  output fld_t       mon_o,
  output fld_t       year_o
);
  fld_t dow_q, day_q, mon_q, year_q;
  stp_t w_nx, d_nx, mo_nx, y_nx;
  logic [6:0] last_day;

  always_comb begin
    last_day = days_in_month(dec(mon_q, bin_i), dec(year_q, bin_i));
    w_nx  = step_wrap(dow_q,  bin_i, 7'd1, 7'd7);
    d_nx  = step_wrap(day_q,  bin_i, 7'd1, last_day);
    mo_nx = step_wrap(mon_q,  bin_i, 7'd1, 7'd12);
    y_nx  = step_wrap(year_q, bin_i, 7'd0, 7'd99);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q  <= 8'h01;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (ld_i) begin
      case (ld_sel_i)
        SEL_DOW:  dow_q  <= ld_data_i;
        SEL_DAY:  day_q  <= ld_data_i;
        SEL_MON:  mon_q  <= ld_data_i;
        SEL_YEAR: year_q <= ld_data_i;
        default:  ;
      endcase
    end else if (day_step_i) begin
      dow_q <= w_nx.val;
      day_q <= d_nx.val;
      if (d_nx.wrap) mon_q <= mo_nx.val;
      if (d_nx.wrap && mo_nx.wrap) year_q <= y_nx.val;
    end
  end

  assign dow_o  = dow_q;
  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int UIP_LEAD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       set_i,
  input  logic       bin_mode_i,
  input  logic       hr24_i,
  input  logic       ld_en_i,
  input  logic [2:0] ld_sel_i,
  input  logic [7:0] ld_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic       upd_done_o
);
  logic     step;
  logic     day_roll;
  logic     ld_ok;
  fld_sel_e sel;
  logic     done_q;

  assign ld_ok = set_i && ld_en_i;
  assign sel   = fld_sel_e'(ld_sel_i);

  rtc_uip_seq #(.LEAD(UIP_LEAD)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .halt_i (set_i),
    .uip_o  (uip_o),
    .step_o (step)
  );

  rtc_time_chain u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .bin_i      (bin_mode_i),
    .hr24_i     (hr24_i),
    .ld_i       (ld_ok),
    .ld_sel_i   (sel),
    .ld_data_i  (ld_data_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .day_roll_o (day_roll)
  );

  rtc_date_chain u_date (
    .clk        (clk),
    .rst_n      (rst_n),
    .day_step_i (day_roll),
    .bin_i      (bin_mode_i),
    .ld_i       (ld_ok),
    .ld_sel_i   (sel),
    .ld_data_i  (ld_data_i),
    .dow_o      (dow_o),
    .day_o      (day_o),
    .mon_o      (mon_o),
    .year_o     (year_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= step;
  end

  assign upd_done_o = done_q;
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_i,
  input logic       ld_en_i,
  input logic       step,
  input logic       day_roll,
  input logic       uip_o,
  input logic       upd_done_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] day_o
);
  p_step_inside_uip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> uip_o);

  p_done_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> upd_done_o);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done_o |=> !upd_done_o);

  p_roll_needs_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |-> step);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (!uip_o && !upd_done_o));

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !ld_en_i) |=> ($stable(sec_o) && $stable(hour_o) && $stable(day_o)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !step) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(day_o)));
endmodule

bind rtc_calendar_core rtc_cal_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_i      (set_i),
  .ld_en_i    (ld_en_i),
  .step       (step),
  .day_roll   (day_roll),
  .uip_o      (uip_o),
  .upd_done_o (upd_done_o),
  .sec_o      (sec_o),
  .min_o      (min_o),
  .hour_o     (hour_o),
  .day_o      (day_o)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int LEAD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, set_i = 1'b0, bin_mode_i = 1'b0, hr24_i = 1'b1;
  logic       ld_en_i = 1'b0;
  logic [2:0] ld_sel_i = 3'd0;
  logic [7:0] ld_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, day_o, mon_o, year_o;
  logic       uip_o, upd_done_o;

  rtc_calendar_core #(.UIP_LEAD(LEAD)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_i(set_i),
    .bin_mode_i(bin_mode_i), .hr24_i(hr24_i), .ld_en_i(ld_en_i),
    .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o),
    .uip_o(uip_o), .upd_done_o(upd_done_o)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  logic [55:0] sbq[$];

  int m_s, m_m, m_h, m_dw, m_d, m_mo, m_y;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] benc(input int n);
    return bin_mode_i ? 8'(n) : 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] bhour(input int h);
    logic [7:0] t;
    int h12;
    if (hr24_i) return benc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    t = benc(h12);
    return {(h >= 12), t[6:0]};
  endfunction

  function automatic logic [55:0] snap();
    return {benc(m_s), benc(m_m), bhour(m_h), benc(m_dw), benc(m_d), benc(m_mo), benc(m_y)};
  endfunction

  function automatic logic [55:0] ports();
    return {sec_o, min_o, hour_o, dow_o, day_o, mon_o, year_o};
  endfunction

  function automatic int month_len();
    if (m_mo == 2) return (m_y % 4 == 0) ? 29 : 28;
    if (m_mo == 4 || m_mo == 6 || m_mo == 9 || m_mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_dw = (m_dw == 7) ? 1 : m_dw + 1;
          m_d++;
          if (m_d > month_len()) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin
              m_mo = 1;
              m_y = (m_y + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = val;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic setup(input logic bin, input logic h24, input int s, input int mi, input int h,
                       input int dw, input int d, input int mo, input int y);
    logic [55:0] v;
    @(negedge clk);
    set_i = 1'b1; bin_mode_i = bin; hr24_i = h24;
    m_s = s; m_m = mi; m_h = h; m_dw = dw; m_d = d; m_mo = mo; m_y = y;
    v = snap();
    for (int i = 0; i < 7; i++) load(3'(i), v[55 - 8*i -: 8]);
    @(negedge clk);
    set_i = 1'b0;
  endtask

  task automatic tick_raw(input string req);
    cur_req = req;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    check({req, " R2 uip raised"}, 64'(uip_o), 64'd1);
    repeat (LEAD) @(negedge clk);
    check({req, " R2 uip dropped"}, 64'(uip_o), 64'd0);
    @(negedge clk);
    check({req, " R3 pulse single"}, 64'(upd_done_o), 64'd0);
  endtask

  task automatic tick_expect(input string req);
    model_advance();
    sbq.push_back(snap());
    tick_raw(req);
  endtask

  // Monitor: compare each completed update against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && upd_done_o) begin
      if (sbq.size() == 0) begin
        check({cur_req, " R3 unexpected update"}, 64'(upd_done_o), 64'd0);
      end else begin
        logic [55:0] e;
        e = sbq.pop_front();
        check(cur_req, 64'(ports()), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [55:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fields", 64'(ports()), 64'({8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00}));
    check("R1 uip", 64'(uip_o), 64'd0);
    check("R1 done", 64'(upd_done_o), 64'd0);

    // R4 minute/hour carry
    setup(1'b0, 1'b1, 59, 14, 10, 2, 5, 3, 21);
    tick_expect("R4 sec/min carry");
    // R12 BCD digit carries
    setup(1'b0, 1'b1, 8, 0, 0, 3, 15, 6, 45);
    tick_expect("R12 bcd 09");
    tick_expect("R12 bcd 10");
    setup(1'b0, 1'b1, 19, 0, 0, 3, 15, 6, 45);
    tick_expect("R12 bcd 20");
    // R12 binary plain add
    setup(1'b1, 1'b1, 8, 0, 0, 3, 15, 6, 45);
    tick_expect("R12 bin 09");
    tick_expect("R12 bin 0A");
    // R5 R8 R9 full rollover
    setup(1'b0, 1'b1, 59, 59, 23, 7, 31, 12, 99);
    tick_expect("R5 R8 R9 year wrap");
    // R7 month lengths
    setup(1'b1, 1'b1, 59, 59, 23, 2, 28, 2, 3);
    tick_expect("R7 feb 28 common");
    setup(1'b1, 1'b1, 59, 59, 23, 2, 28, 2, 4);
    tick_expect("R7 feb 28 leap");
    setup(1'b1, 1'b1, 59, 59, 23, 3, 29, 2, 4);
    tick_expect("R7 feb 29 leap");
    setup(1'b0, 1'b1, 59, 59, 23, 4, 28, 2, 0);
    tick_expect("R7 year 00 leap");
    setup(1'b0, 1'b1, 59, 59, 23, 5, 30, 4, 22);
    tick_expect("R7 apr 30");
    setup(1'b0, 1'b1, 59, 59, 23, 6, 31, 1, 22);
    tick_expect("R7 R9 jan 31");
    // R6 12-hour format
    setup(1'b0, 1'b0, 59, 59, 11, 1, 10, 7, 30);
    tick_expect("R6 11am to 12pm");
    setup(1'b0, 1'b0, 59, 59, 12, 1, 10, 7, 30);
    tick_expect("R6 12pm to 1pm");
    setup(1'b0, 1'b0, 59, 59, 23, 1, 10, 7, 30);
    tick_expect("R6 11pm to 12am");
    setup(1'b1, 1'b0, 59, 59, 23, 7, 30, 9, 30);
    tick_expect("R6 bin 11pm rollover");

    // R10 halt: tick ignored, no count, uip low
    setup(1'b0, 1'b1, 30, 10, 10, 2, 2, 2, 2);
    @(negedge clk); set_i = 1'b1;
    cur_req = "R10 halted tick";
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    check("R10 uip held low", 64'(uip_o), 64'd0);
    repeat (LEAD + 2) @(negedge clk);
    check("R10 frozen fields", 64'(ports()), 64'(snap()));
    load(3'd6, 8'h47);
    m_y = 47;
    check("R10 load year", 64'(year_o), 64'h47);
    @(negedge clk); set_i = 1'b0;
    load(3'd0, 8'h33);
    check("R10 load ignored running", 64'(sec_o), 64'(benc(m_s)));

    // R11 mode change keeps stored bits
    setup(1'b0, 1'b1, 29, 0, 5, 2, 2, 2, 2);
    old = snap();
    @(negedge clk); bin_mode_i = 1'b1;
    @(negedge clk);
    check("R11 no conversion", 64'(ports()), 64'(old));
    sbq.push_back({8'h2A, old[47:0]});
    tick_raw("R11 bin step on bcd bits");

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", 64'(sbq.size()), 64'd0);
    finish_up();
  end
endmodule